// File: doc/BRIEF.md
# Dual-Mode Synchronous Serial Port

This block is a clocked serial port for a small controller. In its first mode it runs a full-duplex shift register of 4 or 8 bits. It drives SCK itself from a slow reference enable or follows an SCK supplied by a peer, and it shifts on the rising or the falling edge. Incoming bits are taken from SI, or from the SO wire when that wire is turned around to act as an input. In its second mode the port only listens: SCK and both data wires are inputs, and 26-bit words are collected on the rising edges of the external clock.

Every pad input passes through a synchronizer into the system clock domain before use. The CPU sees four register addresses. Address 0 holds control and status, address 1 starts a transfer and returns the received byte, address 2 acknowledges the interrupt, and address 3 returns the last 26-bit word. One interrupt request line is set when a first-mode transfer ends. In the second mode it is set either once per word or on every clock edge.

Top module: `ssp_port`

## Requirements
- R1: After reset, irq is 0, sck_out is 1, sck_oe and so_oe are 1, and a read of address 0 returns 0.
- R2: A write to address 1 starts a first-mode transfer. The length is 8 bits when control bit 0 is 1 and 4 bits when it is 0 (the low nibble of the written byte). Bits go out MSB first. Once the port is idle, a read of address 1 returns the received bits with the first bit in the MSB, zero-extended for 4-bit transfers.
- R3: With control bit 1 at 0, sck_out idles high. During a transfer it toggles once per ref_tick pulse and nowhere else, for exactly 2N toggles in an N-bit transfer, and it ends high.
- R4: With control bit 2 at 0 the port samples the line on rising SCK edges; with it at 1 it samples on falling edges. so_out shows the MSB from the start and moves to the next bit at each sampling edge.
- R5: With control bit 1 at 1, sck_oe is 0, the port shifts on the selected edge of the synchronized sck_in, and it finishes after N such edges.
- R6: While busy (address 0 bit 8), writes to address 1 and address 0 are ignored.
- R7: When a first-mode transfer ends, irq is set if control bit 4 (interrupt enable) is 1, and it stays 0 otherwise.
- R8: A write to address 2 clears irq. If an interrupt event falls in the same cycle, irq stays set.
- R9: With control bit 3 at 1, sck_oe and so_oe are 0. Every 26 rising edges of sck_in form one word, first bit in the MSB, which is readable at address 3.
- R10: In the second mode with interrupts enabled, control bit 6 at 1 sets irq on every sck_in rising edge, four clocks after the pin rises. With bit 6 at 0, irq is set only when the 26th bit completes a word.
- R11: With control bit 5 at 1, so_oe is 0, data is taken from so_in, and si_in has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 26 | Register read data (combinational) |
| ref_tick | input | 1 | Reference enable that paces the internal SCK |
| sck_in | input | 1 | SCK pad input |
| sck_out | output | 1 | SCK pad output value |
| sck_oe | output | 1 | SCK pad output enable |
| si_in | input | 1 | SI pad input |
| so_in | input | 1 | SO pad input |
| so_out | output | 1 | SO pad output value |
| so_oe | output | 1 | SO pad output enable |
| irq | output | 1 | Interrupt request |

## Verification
The interrupt flag can be set and cleared in the same clock: an acknowledge write can land in the cycle where a second-mode edge or a first-mode completion sets the flag. The bench provokes the clash by counting from the sck_in rise through the two synchronizer stages and the edge register, then placing the address-2 write so that it is sampled on that same edge. It expects irq to stay high. As a control, it moves the write one cycle later and expects irq to clear.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_ACK  = 2'd2,
        REG_WORD = 2'd3
    } ssp_reg_e;

    localparam int CTRL_W = 7;

    // Control register: the packed order is the bit order (bit 6 down to bit 0)
    typedef struct packed {
        logic irq_each;  // bit 6: second mode interrupts on every edge
        logic so_rx;     // bit 5: SO wire turned around as data input
        logic irq_en;    // bit 4: interrupt enable
        logic mode2;     // bit 3: receive-only 26-bit mode
        logic fall_edge; // bit 2: sample on falling SCK edge
        logic ext_clk;   // bit 1: SCK from pad
        logic len8;      // bit 0: 8-bit transfer
    } ssp_ctrl_t;

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] st;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.st[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            s_d.st[i] = s_q.st[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st <= {STAGES{RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.st[STAGES-1];

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int DATA_W  = 8,
    parameter int SHORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              cfg_long,
    input  logic              cfg_ext,
    input  logic              cfg_fall,
    input  logic              ref_tick,
    input  logic              sck_sync,
    input  logic              din,
    output logic              busy,
    output logic              done,
    output logic              sck_o,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_data
);

    localparam int CNT_W = $clog2(2 * DATA_W + 1);
    localparam logic [CNT_W-1:0] TOG_LONG  = CNT_W'(2 * DATA_W);
    localparam logic [CNT_W-1:0] TOG_SHORT = CNT_W'(2 * SHORT_W);
    localparam logic [CNT_W-1:0] BIT_LONG  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] BIT_SHORT = CNT_W'(SHORT_W);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              done;
        logic              sck;
        logic              prev;
        logic              long_l;
        logic              ext_l;
        logic              fall_l;
    } shf_state_t;

    shf_state_t       s_d, s_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] tog_lim;
    logic [CNT_W-1:0] bit_lim;
    logic             ext_rise;
    logic             ext_fall;
    logic             ext_act;
    logic             int_act;

    assign cnt_nx   = s_q.cnt + CNT_W'(1);
    assign tog_lim  = s_q.long_l ? TOG_LONG : TOG_SHORT;
    assign bit_lim  = s_q.long_l ? BIT_LONG : BIT_SHORT;
    assign ext_rise = sck_sync & ~s_q.prev;
    assign ext_fall = ~sck_sync & s_q.prev;
    assign ext_act  = s_q.fall_l ? ext_fall : ext_rise;
    // internal SCK: a toggle from 1 is a falling edge, from 0 a rising one
    assign int_act  = s_q.fall_l ? s_q.sck : ~s_q.sck;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.prev = sck_sync;
        if (!s_q.busy) begin
            s_d.sck = 1'b1;
            if (start && enable) begin
                s_d.busy   = 1'b1;
                s_d.cnt    = '0;
                s_d.long_l = cfg_long;
                s_d.ext_l  = cfg_ext;
                s_d.fall_l = cfg_fall;
                s_d.sh     = cfg_long ? tx_data
                                      : {tx_data[SHORT_W-1:0], {(DATA_W-SHORT_W){1'b0}}};
            end
        end else if (!s_q.ext_l) begin
            if (ref_tick) begin
                s_d.sck = ~s_q.sck;
                s_d.cnt = cnt_nx;
                if (int_act) begin
                    s_d.sh = {s_q.sh[DATA_W-2:0], din};
                end
                if (cnt_nx == tog_lim) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end else begin
            if (ext_act) begin
                s_d.sh  = {s_q.sh[DATA_W-2:0], din};
                s_d.cnt = cnt_nx;
                if (cnt_nx == bit_lim) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sck  <= 1'b1;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign sck_o   = s_q.sck;
    assign sdo     = s_q.sh[DATA_W-1];
    assign rx_data = s_q.long_l ? s_q.sh
                                : {{(DATA_W-SHORT_W){1'b0}}, s_q.sh[SHORT_W-1:0]};

endmodule

// File: rtl/ssp_rx_word.sv
module ssp_rx_word #(
    parameter int WORD_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sck_sync,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              edge_pulse,
    output logic              word_pulse
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic              prev;
        logic              edge_p;
        logic              word_p;
    } rxw_state_t;

    rxw_state_t        s_d, s_q;
    logic [WORD_W-1:0] sh_nx;

    assign sh_nx = {s_q.sh[WORD_W-2:0], din};

    always_comb begin
        s_d        = s_q;
        s_d.edge_p = 1'b0;
        s_d.word_p = 1'b0;
        s_d.prev   = sck_sync;
        if (!enable) begin
            s_d.cnt = '0;
        end else if (sck_sync && !s_q.prev) begin
            s_d.sh     = sh_nx;
            s_d.edge_p = 1'b1;
            if (s_q.cnt == LAST) begin
                s_d.cnt    = '0;
                s_d.word   = sh_nx;
                s_d.word_p = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign word       = s_q.word;
    assign edge_pulse = s_q.edge_p;
    assign word_pulse = s_q.word_p;

endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SHORT_W     = 4,
    parameter int WORD_W      = 26,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              ref_tick,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              si_in,
    input  logic              so_in,
    output logic              so_out,
    output logic              so_oe,
    output logic              irq
);

    localparam int PIN_W = 3;

    typedef struct packed {
        ssp_ctrl_t ctrl;
        logic      irq;
    } top_state_t;

    top_state_t        s_d, s_q;
    logic [PIN_W-1:0]  pins_sync;
    logic              sck_s, si_s, so_s;
    logic              din_sel;
    logic              m1_busy, m1_done, m1_sck, m1_sdo;
    logic [DATA_W-1:0] m1_rx;
    logic [WORD_W-1:0] m2_word;
    logic              m2_edge, m2_word_p;
    logic              wr_ctrl, wr_start, ack_wr;
    logic              irq_set;
    logic              mode2_on, ext_on, irq_on;

    ssp_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, si_in, so_in}),
        .q     (pins_sync)
    );

    assign {sck_s, si_s, so_s} = pins_sync;
    assign din_sel  = s_q.ctrl.so_rx ? so_s : si_s;
    assign mode2_on = s_q.ctrl.mode2;
    assign ext_on   = s_q.ctrl.ext_clk;
    assign irq_on   = s_q.ctrl.irq_en;

    assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL) && !m1_busy;
    assign wr_start = wr_en && (wr_addr == REG_DATA) && !m1_busy && !mode2_on;
    assign ack_wr   = wr_en && (wr_addr == REG_ACK);

    ssp_shifter #(
        .DATA_W  (DATA_W),
        .SHORT_W (SHORT_W)
    ) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (!mode2_on),
        .start    (wr_start),
        .tx_data  (wr_data[DATA_W-1:0]),
        .cfg_long (s_q.ctrl.len8),
        .cfg_ext  (ext_on),
        .cfg_fall (s_q.ctrl.fall_edge),
        .ref_tick (ref_tick),
        .sck_sync (sck_s),
        .din      (din_sel),
        .busy     (m1_busy),
        .done     (m1_done),
        .sck_o    (m1_sck),
        .sdo      (m1_sdo),
        .rx_data  (m1_rx)
    );

    ssp_rx_word #(
        .WORD_W (WORD_W)
    ) u_rxw (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (mode2_on),
        .sck_sync   (sck_s),
        .din        (din_sel),
        .word       (m2_word),
        .edge_pulse (m2_edge),
        .word_pulse (m2_word_p)
    );

    assign irq_set = irq_on & (m1_done |
                     (mode2_on & (s_q.ctrl.irq_each ? m2_edge : m2_word_p)));

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) begin
            s_d.ctrl = ssp_ctrl_t'(wr_data[CTRL_W-1:0]);
        end
        s_d.irq = irq_set | (s_q.irq & ~ack_wr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (rd_addr)
            REG_CTRL: rd_data = WORD_W'({s_q.irq, m1_busy, 1'b0, s_q.ctrl});
            REG_DATA: rd_data = WORD_W'(m1_rx);
            REG_WORD: rd_data = m2_word;
            default:  rd_data = '0;
        endcase
    end

    assign sck_out = m1_sck;
    assign sck_oe  = !mode2_on && !ext_on;
    assign so_out  = m1_sdo;
    assign so_oe   = !mode2_on && !s_q.ctrl.so_rx;
    assign irq     = s_q.irq;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic mode2,
    input logic ext_clk,
    input logic irq_en,
    input logic ref_tick,
    input logic sck_out,
    input logic sck_oe,
    input logic so_oe,
    input logic irq,
    input logic ack_wr,
    input logic irq_set
);

    AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !mode2 && !ext_clk) |-> sck_out); // R3

    AST_SCK_PACED_BY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_clk && !mode2 && !$stable(sck_out)) |-> $past(ref_tick)); // R3

    AST_MODE2_RELEASES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        mode2 |-> (!sck_oe && !so_oe)); // R9

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en)); // R7

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && irq_en && !ack_wr) |=> irq); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !irq_set) |=> !irq); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq); // R8

endmodule

bind ssp_port ssp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (m1_busy),
    .mode2    (mode2_on),
    .ext_clk  (ext_on),
    .irq_en   (irq_on),
    .ref_tick (ref_tick),
    .sck_out  (sck_out),
    .sck_oe   (sck_oe),
    .so_oe    (so_oe),
    .irq      (irq),
    .ack_wr   (ack_wr),
    .irq_set  (irq_set)
);

// File: tb/sim_ssp_port.sv
module sim_ssp_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [25:0] rd_data;
    logic        ref_tick = 1'b0;
    logic        sck_in = 1'b1;
    logic        sck_out, sck_oe;
    logic        si_in = 1'b0;
    logic        so_in = 1'b0;
    logic        so_out, so_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    ssp_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ref_tick(ref_tick),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .si_in(si_in), .so_in(so_in), .so_out(so_out), .so_oe(so_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [25:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic set_line(input bit b, input bit sorx);
        if (sorx) begin
            so_in = b; si_in = ~b;
        end else begin
            si_in = b; so_in = 1'($urandom % 2);
        end
    endtask

    function automatic logic [6:0] mk_ctrl(input bit each, sorx, ien, m2, fall, ext, long8);
        return {each, sorx, ien, m2, fall, ext, long8};
    endfunction

    // one first-mode transfer; bench plays the peer
    task automatic m1_xfer(input logic [7:0] tx, input logic [7:0] rxv, input bit long8,
                           input bit ext, input bit fall, input bit sorx, input bit ien,
                           input bit poke);
        int n;
        int k;
        int tog;
        int so_bad;
        logic prev_sck;
        logic so_prev;
        logic [6:0] c;
        logic [25:0] v;
        logic [7:0] exp_rx;
        n = long8 ? 8 : 4;
        k = 0; tog = 0; so_bad = 0;
        c = mk_ctrl(1'b0, sorx, ien, 1'b0, fall, ext, long8);
        wr(2'd0, {1'b0, c});
        wr(2'd2, 8'h00);
        sck_in = 1'b1;
        set_line(rxv[n-1], sorx);
        repeat (4) @(negedge clk);
        wr(2'd1, tx);
        rd(2'd0, v);
        chk(v[8] == 1'b1, "R6 busy after start", int'(v[8]), 1);
        chk(so_oe == !sorx, "R11 so_oe", int'(so_oe), int'(!sorx));
        chk(sck_oe == !ext, "R5 sck_oe", int'(sck_oe), int'(!ext));
        if (ext) begin
            for (int i = 0; i < n; i++) begin
                sck_in = fall;
                repeat (6) @(negedge clk);
                set_line(rxv[n-1-i], sorx);
                repeat (6) @(negedge clk);
                if (!sorx && so_out !== tx[n-1-i]) so_bad++;
                sck_in = ~fall;
                repeat (6) @(negedge clk);
            end
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
        end else begin
            rd_addr = 2'd0;
            prev_sck = sck_out;
            so_prev = so_out;
            for (int cc = 0; cc < 60 * n; cc++) begin
                @(negedge clk);
                if (sck_out != prev_sck) begin
                    tog++;
                    if (fall ? (prev_sck && !sck_out) : (!prev_sck && sck_out)) begin
                        if (!sorx && k < n && so_prev !== tx[n-1-k]) so_bad++;
                        k++;
                        if (k < n) set_line(rxv[n-1-k], sorx);
                    end
                end
                prev_sck = sck_out;
                so_prev = so_out;
                ref_tick = (cc % 8 == 0);
                if (poke && cc == 20) begin
                    wr_en = 1'b1; wr_addr = 2'd1; wr_data = ~tx;
                end else if (poke && cc == 21) begin
                    wr_addr = 2'd0; wr_data = {1'b0, c ^ 7'h0A};
                end else begin
                    wr_en = 1'b0;
                end
                #1;
                if (rd_data[8] == 1'b0 && cc > 1) break;
            end
            ref_tick = 1'b0;
            chk(tog == 2 * n, "R3 toggle count", tog, 2 * n);
            chk(sck_out == 1'b1, "R3 SCK ends high", int'(sck_out), 1);
        end
        repeat (3) @(negedge clk);
        exp_rx = long8 ? rxv : {4'h0, rxv[3:0]};
        rd(2'd1, v);
        chk(v[7:0] == exp_rx, sorx ? "R11 rx from SO wire" : (ext ? "R5 rx ext clock" : "R2 rx data"),
            int'(v[7:0]), int'(exp_rx));
        chk(so_bad == 0, fall ? "R4 SO bits falling" : "R4 SO bits rising", so_bad, 0);
        rd(2'd0, v);
        chk(v[8] == 1'b0, "R2 idle after transfer", int'(v[8]), 0);
        chk(irq == ien, "R7 completion irq", int'(irq), int'(ien));
        if (poke) chk(v[6:0] == c, "R6 ctrl write ignored while busy", int'(v[6:0]), int'(c));
        wr(2'd2, 8'h00);
        chk(irq == 1'b0, "R8 ack clears", int'(irq), 0);
    endtask

    task automatic m2_word(input logic [25:0] w, input bit each, input bit sorx);
        logic [25:0] v;
        int hits;
        hits = 0;
        wr(2'd0, {1'b0, mk_ctrl(each, sorx, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0)});
        wr(2'd2, 8'h00);
        chk(sck_oe == 1'b0 && so_oe == 1'b0, "R9 pins released", int'({sck_oe, so_oe}), 0);
        for (int i = 0; i < 26; i++) begin
            sck_in = 1'b0;
            set_line(w[25-i], sorx);
            repeat (6) @(negedge clk);
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
            if (each) begin
                if (irq) hits++;
                wr(2'd2, 8'h00);
            end else if (i < 25) begin
                if (irq) hits++;
            end else begin
                chk(irq == 1'b1, "R10 irq at word end", int'(irq), 1);
            end
        end
        chk(hits == (each ? 26 : 0), "R10 per-edge irq count", hits, each ? 26 : 0);
        rd(2'd3, v);
        chk(v == w, sorx ? "R11 word from SO wire" : "R9 word", int'(v), int'(w));
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [25:0] v;
        void'($urandom(32'd1357));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, v);
        chk(v == 26'd0, "R1 status", int'(v), 0);
        chk(irq == 1'b0 && sck_out == 1'b1, "R1 irq/sck", int'({irq, sck_out}), 1);
        chk(sck_oe == 1'b1 && so_oe == 1'b1, "R1 enables", int'({sck_oe, so_oe}), 3);

        // directed corner cases
        m1_xfer(8'hA5, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        m1_xfer(8'h09, 8'h06, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        m1_xfer(8'h81, 8'hFE, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        m1_xfer(8'h0E, 8'h0B, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        m1_xfer(8'h55, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        m1_xfer(8'h5A, 8'h96, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);

        // random transfers
        for (int i = 0; i < 14; i++) begin
            m1_xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        end

        // second mode
        m2_word(26'h2A5_F00F, 1'b0, 1'b0);
        m2_word(26'($urandom), 1'b1, 1'b0);
        m2_word(26'($urandom), 1'b0, 1'b1);

        // R8: ack and per-edge event in the same cycle
        wr(2'd0, {1'b0, mk_ctrl(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0)});
        sck_in = 1'b0; repeat (6) @(negedge clk);
        sck_in = 1'b1; repeat (6) @(negedge clk);
        chk(irq == 1'b1, "R10 edge irq", int'(irq), 1);
        sck_in = 1'b0; repeat (6) @(negedge clk);
        sck_in = 1'b1;
        repeat (3) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2;
        @(negedge clk);
        wr_en = 1'b0;
        chk(irq == 1'b1, "R8 set wins over ack", int'(irq), 1);
        sck_in = 1'b0; repeat (6) @(negedge clk);
        wr(2'd2, 8'h00);
        sck_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, "R10 irq four clocks after rise", int'(irq), 1);
        wr_en = 1'b1; wr_addr = 2'd2;
        @(negedge clk);
        wr_en = 1'b0;
        chk(irq == 1'b0, "R8 late ack clears", int'(irq), 0);
        wr(2'd0, 8'h00);

        // R6: data write in second mode does not start a transfer
        wr(2'd0, {1'b0, mk_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0)});
        wr(2'd1, 8'hFF);
        rd(2'd0, v);
        chk(v[8] == 1'b0, "R6 no start in second mode", int'(v[8]), 0);
        wr(2'd0, 8'h00);

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule